// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block folds every interrupt source of a serial port into one level interrupt request and one readable identification byte. It holds the four-bit interrupt enable register and the transmit-empty pending flag, and every clock it picks the most urgent active source from the line-error status, the character-timeout flag, the receive-data state (qualified by the receive FIFO fill level against the trigger level), the pending transmit-empty flag and the modem-status change bits.

The surrounding serial port supplies single-cycle strobes for a write of the enable register, a read of the identification register and a write of the transmit holding register, plus a strobe when the transmitter has drained. Status vectors arrive as plain levels. The identification byte and the interrupt line are registered, so both show the result for the inputs and state of the previous clock.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous active-low reset the identification byte reads 0x01, the interrupt line is low, the enable register reads 0 and the transmit-empty pending flag is clear.
- R2: A write of the enable register keeps only bits 3:0 of the write data: bit 0 enables receive data and character timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status; the stored value is visible on `ier_q` one clock after the strobe.
- R3: When enable bit 2 is set and any `line_err` bit (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) is set, the ID nibble is 0x6, over every other source.
- R4: When enable bit 0 is set and `rx_timeout` is high, the ID nibble is 0xC unless the line-status source is active; with enable bit 0 clear the timeout never shows.
- R5: When enable bit 0 is set and `data_ready` is high, the receive-data source (ID 0x4) is active if FIFOs are disabled, or if FIFOs are enabled and `rx_count` is at least `trig_level`; it ranks below the timeout.
- R6: When enable bit 1 is set and the transmit-empty pending flag is set, the ID nibble is 0x2 unless a higher source is active.
- R7: When enable bit 3 is set and any `msr_delta` bit is set, the ID nibble is 0x0 only if no other source is active; with nothing active the nibble is 0x1.
- R8: `tx_empty_evt` sets the pending flag and `thr_wr` clears it; a set and a clear in the same clock leave it set.
- R9: A write of the enable register while `thr_empty` is high sets the pending flag.
- R10: A read strobe of the identification register while the byte shows ID 0x2 clears the pending flag; a read while another ID shows leaves it unchanged.
- R11: Bits 7:6 of the identification byte read 11 when `fifo_en` was high in the previous clock and 00 otherwise; bits 5:4 read 0.
- R12: The interrupt line is high exactly when the registered ID nibble is not 0x1; both follow inputs with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Write data for the enable register |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| tx_empty_evt | input | 1 | Transmitter drained strobe |
| thr_empty | input | 1 | Holding register empty status level |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| data_ready | input | 1 | Receive data present |
| rx_timeout | input | 1 | Character timeout flag |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill level |
| trig_level | input | CNT_W | Receive trigger level |
| msr_delta | input | 4 | Modem status change bits |
| ier_q | output | 4 | Stored enable register |
| iir_byte | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the strobes are single-cycle pulses from a bus decoder and that the status inputs are stable levels sampled at the clock edge; nothing else is assumed about their combination, so any mix of sources may be active together. The stimulus drives inputs only just after a falling edge, pulses each strobe for one cycle, keeps `rx_count` within the FIFO range and picks trigger levels of 1, 4, 8 and 14. Directed phases walk each source and each pending-flag rule, then a long randomized phase with rare line errors lets the lower priorities show through.

// File: rtl/uart_irq_pkg.sv
// Shared codes and bit positions for the interrupt identifier.
// Assumes a four-bit enable register and a four-bit ID nibble.
package uart_irq_pkg;
    localparam int EN_W     = 4;
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_THRE    = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_TIMEOUT = 4'hC
    } irq_id_e;
endpackage

// File: rtl/uart_irq_ctrl_regs.sv
// Holds the interrupt enable register and the transmit-empty pending flag.
// Assumes all strobes are single-cycle pulses; set requests win over clears.
module uart_irq_ctrl_regs
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ier_wr,
    input  logic [7:0]      ier_wdata,
    input  logic            iir_rd,
    input  logic            thr_wr,
    input  logic            tx_empty_evt,
    input  logic            thr_empty,
    input  irq_id_e         shown_id,
    output logic [EN_W-1:0] en_q,
    output logic            thr_pend_q
);
    logic pend_set;
    logic pend_clr;

    // Decode the set and clear requests for the pending flag.
    always_comb begin
        pend_set = tx_empty_evt || (ier_wr && thr_empty);
        pend_clr = thr_wr || (iir_rd && (shown_id == ID_THRE));
    end

    // Store the enable bits on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (ier_wr)
            en_q <= ier_wdata[EN_W-1:0];
    end

    // Update the transmit-empty pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_pend_q <= 1'b0;
        else if (pend_set)
            thr_pend_q <= 1'b1;
        else if (pend_clr)
            thr_pend_q <= 1'b0;
    end

    p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |=> thr_pend_q);
    p_wr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !tx_empty_evt && !(ier_wr && thr_empty)) |=> !thr_pend_q);
    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && thr_empty) |=> thr_pend_q);
    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && shown_id == ID_THRE && !tx_empty_evt && !(ier_wr && thr_empty))
        |=> !thr_pend_q);
    p_read_other_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && shown_id != ID_THRE && !thr_wr && !tx_empty_evt && !ier_wr)
        |=> thr_pend_q == $past(thr_pend_q));
    p_ier_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> en_q == $past(ier_wdata[EN_W-1:0]));
endmodule

// File: rtl/uart_irq_prio.sv
// Combinational fixed-priority selector of the interrupt ID nibble.
// Assumes status inputs are levels; the timeout source shares the receive enable.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [EN_W-1:0]  en,
    input  logic [3:0]       line_err,
    input  logic             rx_timeout,
    input  logic             data_ready,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             thr_pend,
    input  logic [3:0]       msr_delta,
    output irq_id_e          id
);
    logic line_act;
    logic tmo_act;
    logic rx_act;
    logic tx_act;
    logic mdm_act;
    logic level_ok;

    // Qualify each source with its enable bit.
    always_comb begin
        level_ok = !fifo_en || (rx_count >= trig_level);
        line_act = en[EN_LINE] && (|line_err);
        tmo_act  = en[EN_RX] && rx_timeout;
        rx_act   = en[EN_RX] && data_ready && level_ok;
        tx_act   = en[EN_TX] && thr_pend;
        mdm_act  = en[EN_MODEM] && (|msr_delta);
    end

    // Pick the most urgent active source.
    always_comb begin
        if (line_act)      id = ID_LINE;
        else if (tmo_act)  id = ID_TIMEOUT;
        else if (rx_act)   id = ID_RXDATA;
        else if (tx_act)   id = ID_THRE;
        else if (mdm_act)  id = ID_MODEM;
        else               id = ID_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identifier: enable/pending registers, priority
// selector and the registered identification byte and interrupt line.
// Assumes strobes are single-cycle pulses from the bus decoder.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic             tx_empty_evt,
    input  logic             thr_empty,
    input  logic [3:0]       line_err,
    input  logic             data_ready,
    input  logic             rx_timeout,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic [3:0]       msr_delta,
    output logic [EN_W-1:0]  ier_q,
    output logic [7:0]       iir_byte,
    output logic             irq
);
    irq_id_e id_next;
    irq_id_e id_q;
    logic    fifo_q;
    logic    thr_pend;

    uart_irq_ctrl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ier_wr       (ier_wr),
        .ier_wdata    (ier_wdata),
        .iir_rd       (iir_rd),
        .thr_wr       (thr_wr),
        .tx_empty_evt (tx_empty_evt),
        .thr_empty    (thr_empty),
        .shown_id     (id_q),
        .en_q         (ier_q),
        .thr_pend_q   (thr_pend)
    );

    uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
        .en         (ier_q),
        .line_err   (line_err),
        .rx_timeout (rx_timeout),
        .data_ready (data_ready),
        .fifo_en    (fifo_en),
        .rx_count   (rx_count),
        .trig_level (trig_level),
        .thr_pend   (thr_pend),
        .msr_delta  (msr_delta),
        .id         (id_next)
    );

    // Register the selected ID, the FIFO flag and the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= ID_NONE;
            fifo_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            id_q   <= id_next;
            fifo_q <= fifo_en;
            irq    <= (id_next != ID_NONE);
        end
    end

    // Assemble the readable identification byte.
    always_comb iir_byte = {fifo_q, fifo_q, 2'b00, id_q};

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == '0) |=> (iir_byte[3:0] == ID_NONE) && !irq);
    p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[EN_LINE] && (|line_err)) |=> iir_byte[3:0] == ID_LINE);
    p_timeout_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_q[EN_RX] |=> (iir_byte[3:0] != ID_TIMEOUT) && (iir_byte[3:0] != ID_RXDATA));
    p_below_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_count < trig_level && !rx_timeout) |=> iir_byte[3:0] != ID_RXDATA);
    p_fifo_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (iir_byte[7:6] == {2{$past(fifo_en)}}) && (iir_byte[5:4] == 2'b00));
    p_irq_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_byte[3:0] != ID_NONE));
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ier_wr = 0, iir_rd = 0, thr_wr = 0, tx_empty_evt = 0, thr_empty = 0;
    logic [7:0] ier_wdata = 0;
    logic [3:0] line_err = 0, msr_delta = 0;
    logic data_ready = 0, rx_timeout = 0, fifo_en = 0;
    logic [CNT_W-1:0] rx_count = 0, trig_level = 1;
    logic [3:0] ier_q;
    logic [7:0] iir_byte;
    logic irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    logic [3:0] m_en = 0;
    bit m_pend = 0, m_fifo = 0, m_irq = 0;
    logic [3:0] m_id = 4'h1;

    always #5 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .tx_empty_evt(tx_empty_evt),
        .thr_empty(thr_empty), .line_err(line_err), .data_ready(data_ready),
        .rx_timeout(rx_timeout), .fifo_en(fifo_en), .rx_count(rx_count),
        .trig_level(trig_level), .msr_delta(msr_delta), .ier_q(ier_q),
        .iir_byte(iir_byte), .irq(irq));

    function automatic logic [3:0] pick_id();
        bit act[5];
        logic [3:0] codes[5] = '{4'h6, 4'hC, 4'h4, 4'h2, 4'h0};
        act[0] = m_en[2] && (line_err != 0);
        act[1] = m_en[0] && rx_timeout;
        act[2] = m_en[0] && data_ready && (!fifo_en || int'(rx_count) >= int'(trig_level));
        act[3] = m_en[1] && m_pend;
        act[4] = m_en[3] && (msr_delta != 0);
        for (int k = 0; k < 5; k++)
            if (act[k]) return codes[k];
        return 4'h1;
    endfunction

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: advance the model on the inputs now applied, then compare.
    task automatic step();
        logic [3:0] nid;
        bit npend;
        if (!rst_n) begin
            nid = 4'h1; npend = 0;
            m_en = 0; m_fifo = 0; m_irq = 0;
        end else begin
            nid = pick_id();
            npend = m_pend;
            if (thr_wr || (iir_rd && m_id == 4'h2)) npend = 0;
            if (tx_empty_evt || (ier_wr && thr_empty)) npend = 1;
            if (ier_wr) m_en = ier_wdata[3:0];
            m_fifo = fifo_en;
            m_irq = (nid != 4'h1);
        end
        m_pend = npend;
        m_id = nid;
        @(posedge clk);
        @(negedge clk);
        check("iir_byte", iir_byte, {m_fifo, m_fifo, 2'b00, m_id});
        check("irq", {7'b0, irq}, {7'b0, m_irq});
        check("ier_q", {4'b0, ier_q}, {4'b0, m_en});
        ier_wr = 0; iir_rd = 0; thr_wr = 0; tx_empty_evt = 0;
    endtask

    task automatic wr_ier(logic [7:0] v);
        ier_wr = 1; ier_wdata = v; step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1"; repeat (3) step();
        rst_n = 1; step(); step();
        // R2: only the low four bits stick
        tag = "R2"; wr_ier(8'hF0); step(); wr_ier(8'hA5); step(); wr_ier(8'h00);
        // R3: line error beats everything
        tag = "R3"; wr_ier(8'h0F); thr_empty = 0;
        line_err = 4'b1000; rx_timeout = 1; data_ready = 1; msr_delta = 4'h1; step(); step();
        line_err = 4'b0001; step();
        // R4: timeout next; masked by receive enable
        tag = "R4"; line_err = 0; step(); step();
        wr_ier(8'h0E); step(); wr_ier(8'h0F);
        // R5: receive data with trigger level
        tag = "R5"; rx_timeout = 0; fifo_en = 1; trig_level = 4; rx_count = 3; step(); step();
        rx_count = 4; step(); fifo_en = 0; rx_count = 0; step(); step();
        // R6 / R8: transmit empty pending
        tag = "R8"; data_ready = 0; tx_empty_evt = 1; step(); step();
        tag = "R6"; msr_delta = 4'h2; step();
        tag = "R8"; thr_wr = 1; step(); step();
        thr_wr = 1; tx_empty_evt = 1; step(); step();
        // R10: read clears only when the transmit code shows
        tag = "R10"; iir_rd = 1; step(); step();
        tx_empty_evt = 1; step(); line_err = 4'h2; step(); step();
        iir_rd = 1; step(); line_err = 0; step(); step();
        iir_rd = 1; step(); step();
        // R9: enable write re-arms while holding register empty
        tag = "R9"; thr_empty = 1; wr_ier(8'h0F); step(); thr_empty = 0; iir_rd = 1; step();
        wr_ier(8'h0F); step();
        // R7: modem lowest, then none
        tag = "R7"; step(); msr_delta = 0; step(); step();
        // R11: FIFO bits
        tag = "R11"; fifo_en = 1; step(); step(); fifo_en = 0; step();
        // R12: randomized mix
        tag = "R12";
        for (int i = 0; i < 4000; i++) begin
            ier_wr = ($urandom % 12 == 0); ier_wdata = 8'($urandom);
            iir_rd = ($urandom % 4 == 0); thr_wr = ($urandom % 8 == 0);
            tx_empty_evt = ($urandom % 6 == 0); thr_empty = 1'($urandom);
            line_err = ($urandom % 7 == 0) ? 4'($urandom) : 4'h0;
            data_ready = 1'($urandom); rx_timeout = ($urandom % 5 == 0);
            fifo_en = ($urandom % 3 != 0); rx_count = CNT_W'($urandom % 17);
            case ($urandom % 4)
                0: trig_level = 1; 1: trig_level = 4; 2: trig_level = 8; default: trig_level = 14;
            endcase
            msr_delta = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            if (i == 2000) rst_n = 0;
            if (i == 2003) rst_n = 1;
            step();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule